// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block models the write side of a byte-wide memory that is programmed one page at a time. It sits on top of an internal synchronous byte array and gives the host a strobe-style bus: active-low chip enable, output enable and write enable, an address and an 8-bit data path. Host writes do not reach the array directly. They collect in a 64-byte page latch. When the host stops writing for a set number of clocks, a self-timed cycle commits the page. During that cycle the host bus is free, and reads poll bit 7 of the data to find out when the cycle has ended.

Each page commit acts as an erase followed by a program of the bytes that were loaded, so the host never erases first. A six-write command pattern erases the whole array to 0xFF instead. The cycle length is a clock-count parameter, so a simulation can use a short value in place of a millisecond-scale one.

Top module: `pgwr_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `dout_oe` is low until a read is issued.
- R2: A cycle sampled with `ce_n`=0 and `oe_n`=0 is a read. One clock later `dout_oe` is high and, when no commit cycle is running, `dout` holds the array byte at the sampled address. In any other cycle, `dout_oe` is low one clock later.
- R3: A write is a clock where `ce_n`=0, `oe_n`=1 and `we_n`=0, with `we_n` high at the clock before. Writes fill the page latch. Once LOAD_WIN clocks pass without a write, the commit cycle starts, and every loaded byte can be read back from the array after the cycle.
- R4: A commit changes only the loaded bytes. Bytes of the page that were not loaded, and all other pages, keep their previous contents.
- R5: The page (address bits [ADDR_W-1:6]) is taken from the first write of a load. A later write in the same load goes to its offset (address bits [5:0]) within that page, whatever its upper address bits are.
- R6: While a commit or erase cycle runs, each read returns the last loaded byte with bit 7 inverted, with bits 6..0 unchanged. For a chip erase, the byte used is 0xFF, so reads return 0x7F.
- R7: A commit cycle lasts at least CYCLE_CLKS clocks. After it ends, reads return array data.
- R8: A write that arrives while a cycle runs is ignored. It changes neither the array nor the polled byte.
- R9: The writes (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x10), matched on address bits [10:0], start a chip erase at once. The chip erase sets every location to 0xFF and discards the page latch.
- R10: When a write breaks the command pattern, the pattern is dropped and the write is handled as an ordinary page-load write. No erase takes place.
- R11: When one load writes the same offset twice, the later data is the data programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its falling edge |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, or the polling byte while busy |
| dout_oe | output | 1 | High when `dout` carries a read result |

## Verification
The test starts with a chip erase and then runs several page loads. One is a sparse load of three bytes at the edges of a page. One reloads the same page with a repeated offset, which shows whether unloaded bytes are preserved and whether the last write wins. One load crosses a page boundary, which shows whether the page is fixed by the first write. One is a command pattern broken at its third byte, which separates a true chip erase from an ordinary load. Polling reads taken during each cycle check the inverted bit 7 and the cycle length, and a write issued mid-cycle must leave no trace.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int PAGE_BITS = 6;
  localparam int CMD_LEN   = 6;
  localparam int CMD_AW    = 11;

  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_ERASE,
    ST_HOLD
  } seq_state_t;

  function automatic logic [CMD_AW-1:0] cmd_addr(input logic [2:0] step);
    case (step)
      3'd1, 3'd4: cmd_addr = 11'h2AA;
      default:    cmd_addr = 11'h555;
    endcase
  endfunction

  function automatic byte_t cmd_data(input logic [2:0] step);
    case (step)
      3'd0, 3'd3: cmd_data = 8'hAA;
      3'd1, 3'd4: cmd_data = 8'h55;
      3'd2:       cmd_data = 8'h80;
      default:    cmd_data = 8'h10;
    endcase
  endfunction
endpackage

// File: rtl/pgwr_array.sv
module pgwr_array
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  byte_t             wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output byte_t             rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  byte_t cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
    if (re) begin
      rdata <= cells[raddr];
    end
  end
endmodule

// File: rtl/pgwr_page_latch.sv
module pgwr_page_latch
  import pgwr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 first,
  input  logic                 wr_en,
  input  logic [PAGE_BITS-1:0] wr_off,
  input  byte_t                wr_data,
  input  logic [PAGE_BITS-1:0] rd_off,
  output byte_t                rd_data,
  output logic                 rd_valid
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;

  logic [PAGE_SZ-1:0]      vld_q;
  logic [PAGE_SZ-1:0]      vld_d;
  logic [PAGE_SZ-1:0][7:0] slot_data;

  for (genvar g = 0; g < PAGE_SZ; g++) begin : g_slot
    logic  hit;
    byte_t slot_q;

    assign hit      = wr_en && (wr_off == PAGE_BITS'(g));
    assign vld_d[g] = (first ? 1'b0 : vld_q[g]) | hit;

    always_ff @(posedge clk) begin
      if (hit) begin
        slot_q <= wr_data;
      end
    end

    assign slot_data[g] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign rd_data  = slot_data[rd_off];
  assign rd_valid = vld_q[rd_off];
endmodule

// File: rtl/pgwr_cmd_match.sv
module pgwr_cmd_match
  import pgwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_ok,
  input  logic [CMD_AW-1:0] wr_addr,
  input  byte_t             wr_data,
  output logic              hit
);
  logic [2:0] step_q;
  logic [2:0] step_d;
  logic       step_match;
  logic       restart_match;

  always_comb begin
    step_match    = (wr_addr == cmd_addr(step_q)) && (wr_data == cmd_data(step_q));
    restart_match = (wr_addr == cmd_addr(3'd0)) && (wr_data == cmd_data(3'd0));
    hit           = wr_ok && step_match && (step_q == 3'(CMD_LEN - 1));
    step_d        = step_q;
    if (clr) begin
      step_d = 3'd0;
    end else if (wr_ok) begin
      if (hit) begin
        step_d = 3'd0;
      end else if (step_match) begin
        step_d = step_q + 3'd1;
      end else if (restart_match) begin
        step_d = 3'd1;
      end else begin
        step_d = 3'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 3'd0;
    end else begin
      step_q <= step_d;
    end
  end
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LOAD_WIN   = 16,
  parameter int CYCLE_CLKS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              cmd_hit,
  output logic              busy,
  output logic              load_first,
  output logic              prog_walk,
  output logic              erase_walk,
  output logic              prog_start,
  output logic [ADDR_W-1:0] walk_q
);
  localparam int WIN_W   = $clog2(LOAD_WIN + 1);
  localparam int CYC_W   = $clog2(CYCLE_CLKS + 1);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PAGE_SZ = 1 << PAGE_BITS;

  seq_state_t        st_q, st_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [CYC_W-1:0]  cyc_inc;
  logic [ADDR_W-1:0] walk_d;
  logic              cyc_done;

  assign cyc_done = (cyc_q >= CYC_W'(CYCLE_CLKS - 1));
  assign cyc_inc  = cyc_done ? cyc_q : cyc_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    win_d  = win_q;
    cyc_d  = cyc_q;
    walk_d = walk_q;
    case (st_q)
      ST_IDLE, ST_LOAD: begin
        if (cmd_hit) begin
          st_d   = ST_ERASE;
          walk_d = '0;
          cyc_d  = '0;
        end else if (wr_ok) begin
          st_d  = ST_LOAD;
          win_d = '0;
        end else if (st_q == ST_LOAD) begin
          if (win_q == WIN_W'(LOAD_WIN - 1)) begin
            st_d   = ST_PROG;
            walk_d = '0;
            cyc_d  = '0;
          end else begin
            win_d = win_q + 1'b1;
          end
        end
      end
      ST_PROG: begin
        cyc_d = cyc_inc;
        if (walk_q == ADDR_W'(PAGE_SZ - 1)) begin
          st_d = ST_HOLD;
        end else begin
          walk_d = walk_q + 1'b1;
        end
      end
      ST_ERASE: begin
        cyc_d = cyc_inc;
        if (walk_q == ADDR_W'(DEPTH - 1)) begin
          st_d = ST_HOLD;
        end else begin
          walk_d = walk_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (cyc_done) begin
          st_d = ST_IDLE;
        end else begin
          cyc_d = cyc_inc;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      win_q  <= '0;
      cyc_q  <= '0;
      walk_q <= '0;
    end else begin
      st_q   <= st_d;
      win_q  <= win_d;
      cyc_q  <= cyc_d;
      walk_q <= walk_d;
    end
  end

  assign busy       = (st_q == ST_PROG) || (st_q == ST_ERASE) || (st_q == ST_HOLD);
  assign load_first = wr_ok && (st_q == ST_IDLE);
  assign prog_walk  = (st_q == ST_PROG);
  assign erase_walk = (st_q == ST_ERASE);
  assign prog_start = (st_q == ST_LOAD) && (st_d == ST_PROG);
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LOAD_WIN   = 16,
  parameter int CYCLE_CLKS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe
);
  localparam int PAGE_HI_W = ADDR_W - PAGE_BITS;

  logic [1:0]           rsync_q;
  logic                 rst_sn;
  logic                 we_q;
  logic                 we_fall;
  logic                 wr_ok;
  logic                 rd_en;
  logic                 cmd_hit;
  logic                 busy;
  logic                 load_first;
  logic                 prog_walk;
  logic                 erase_walk;
  logic                 prog_start;
  logic [ADDR_W-1:0]    walk_q;
  logic [PAGE_HI_W-1:0] page_q;
  byte_t                poll_q;
  byte_t                lat_data;
  logic                 lat_valid;
  logic                 mem_we;
  logic [ADDR_W-1:0]    mem_waddr;
  byte_t                mem_wdata;
  byte_t                arr_rdata;
  logic                 rdoe_q;
  logic                 pollrd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_sn = rsync_q[1];

  assign we_fall = !ce_n && oe_n && !we_n && we_q;
  assign wr_ok   = we_fall && !busy;
  assign rd_en   = !ce_n && !oe_n;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      we_q     <= 1'b1;
      rdoe_q   <= 1'b0;
      pollrd_q <= 1'b0;
      page_q   <= '0;
      poll_q   <= 8'hFF;
    end else begin
      we_q   <= we_n;
      rdoe_q <= rd_en;
      if (rd_en) begin
        pollrd_q <= busy;
      end
      if (load_first) begin
        page_q <= addr[ADDR_W-1:PAGE_BITS];
      end
      if (cmd_hit) begin
        poll_q <= 8'hFF;
      end else if (wr_ok) begin
        poll_q <= din;
      end
    end
  end

  pgwr_seq #(
    .ADDR_W    (ADDR_W),
    .LOAD_WIN  (LOAD_WIN),
    .CYCLE_CLKS(CYCLE_CLKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wr_ok     (wr_ok),
    .cmd_hit   (cmd_hit),
    .busy      (busy),
    .load_first(load_first),
    .prog_walk (prog_walk),
    .erase_walk(erase_walk),
    .prog_start(prog_start),
    .walk_q    (walk_q)
  );

  pgwr_cmd_match u_cmd (
    .clk    (clk),
    .rst_n  (rst_sn),
    .clr    (prog_start),
    .wr_ok  (wr_ok),
    .wr_addr(addr[CMD_AW-1:0]),
    .wr_data(din),
    .hit    (cmd_hit)
  );

  pgwr_page_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_sn),
    .first   (load_first),
    .wr_en   (wr_ok),
    .wr_off  (addr[PAGE_BITS-1:0]),
    .wr_data (din),
    .rd_off  (walk_q[PAGE_BITS-1:0]),
    .rd_data (lat_data),
    .rd_valid(lat_valid)
  );

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = walk_q;
    mem_wdata = 8'hFF;
    if (prog_walk) begin
      mem_we    = lat_valid;
      mem_waddr = {page_q, walk_q[PAGE_BITS-1:0]};
      mem_wdata = lat_data;
    end else if (erase_walk) begin
      mem_we = 1'b1;
    end
  end

  pgwr_array #(
    .ADDR_W(ADDR_W)
  ) u_array (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .re   (rd_en),
    .raddr(addr),
    .rdata(arr_rdata)
  );

  assign dout    = pollrd_q ? {~poll_q[7], poll_q[6:0]} : arr_rdata;
  assign dout_oe = rdoe_q;
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int LOAD_WIN   = 16,
  parameter int CYCLE_CLKS = 200
) (
  input logic       clk,
  input logic       rst_sn,
  input logic       ce_n,
  input logic       oe_n,
  input logic       dout_oe,
  input logic       busy,
  input logic       we_fall,
  input logic       wr_ok,
  input logic       cmd_hit,
  input logic [7:0] poll_q
);
  localparam int IW = $clog2(LOAD_WIN + 1);
  localparam int BW = $clog2(CYCLE_CLKS + 1);

  logic [IW-1:0] idle_cnt;
  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      idle_cnt <= '0;
      busy_cnt <= '0;
    end else begin
      if (wr_ok) begin
        idle_cnt <= '0;
      end else if (idle_cnt != IW'(LOAD_WIN)) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
      if (!busy) begin
        busy_cnt <= '0;
      end else if (busy_cnt != BW'(CYCLE_CLKS)) begin
        busy_cnt <= busy_cnt + 1'b1;
      end
    end
  end

  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ce_n && !oe_n) |=> dout_oe);

  a_r2_no_read_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    !(!ce_n && !oe_n) |=> !dout_oe);

  a_r3_window_elapsed: assert property (@(posedge clk) disable iff (!rst_sn)
    ($rose(busy) && !$past(cmd_hit)) |-> (idle_cnt >= IW'(LOAD_WIN)));

  a_r7_min_cycle: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy) |-> (busy_cnt >= BW'(CYCLE_CLKS)));

  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && we_fall) |=> $stable(poll_q));

  a_r9_erase_starts: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_hit |=> busy);
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(
  .LOAD_WIN  (LOAD_WIN),
  .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk    (clk),
  .rst_sn (rst_sn),
  .ce_n   (ce_n),
  .oe_n   (oe_n),
  .dout_oe(dout_oe),
  .busy   (busy),
  .we_fall(we_fall),
  .wr_ok  (wr_ok),
  .cmd_hit(cmd_hit),
  .poll_q (poll_q)
);

// File: tb/pgwr_ctrl_bench.sv
module pgwr_ctrl_bench;
  localparam int AW  = 12;
  localparam int WIN = 16;
  localparam int CYC = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_oe;

  always #5 clk = ~clk;

  pgwr_ctrl #(.ADDR_W(AW), .LOAD_WIN(WIN), .CYCLE_CLKS(CYC)) u_pgwr_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    errors = 0;
  bit    poll_mode = 1'b0;
  bit    done = 1'b0;
  int    cyc_ctr = 0;

  always @(posedge clk) cyc_ctr <= cyc_ctr + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (dout_oe && !poll_mode) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R2 unexpected read result", {24'h0, dout}, 32'h0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(dout === it.exp, it.tag, {24'h0, dout}, {24'h0, it.exp});
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic poll(input logic [AW-1:0] a, input logic fin, input int maxn,
                      output logic [7:0] first, output logic [7:0] last);
    int n;
    poll_mode = 1'b1;
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    first = dout; n = 1;
    while (dout[7] !== fin && n < maxn) begin
      @(negedge clk);
      n++;
    end
    last = dout;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    poll_mode = 1'b0;
  endtask

  task automatic chip_erase();
    logic [AW-1:0] ca [6];
    logic [7:0]    cd [6];
    logic [7:0]    f, l;
    ca = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'h555};
    cd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
    for (int i = 0; i < 6; i++) wr(ca[i], cd[i]);
    poll(12'h555, 1'b1, 20000, f, l);
    check(f === 8'h7F, "R6 erase polling byte", {24'h0, f}, 32'h7F);
    check(l === 8'hFF, "R9 erase completion", {24'h0, l}, 32'hFF);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] f, l;
    int t0;
    repeat (3) @(negedge clk);
    check(dout_oe === 1'b0, "R1 oe low in reset", {31'h0, dout_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dout_oe === 1'b0, "R1 oe low after reset", {31'h0, dout_oe}, 32'h0);

    chip_erase();
    rd(12'h000, 8'hFF, "R9 erased low");
    rd(12'h555, 8'hFF, "R9 erased cmd addr, latch discarded");
    rd(12'hFFF, 8'hFF, "R9 erased top");

    wr(12'h0C0, 8'h12);
    wr(12'h0C5, 8'h85);
    wr(12'h0FF, 8'h3C);
    t0 = cyc_ctr;
    repeat (WIN) @(negedge clk);
    poll(12'h0FF, 1'b0, 1, f, l);
    check(f === 8'hBC, "R6 program polling byte", {24'h0, f}, 32'hBC);
    wr(12'h200, 8'h00);
    poll(12'h0FF, 1'b0, 5000, f, l);
    check(l === 8'h3C, "R7 data after completion", {24'h0, l}, 32'h3C);
    check((cyc_ctr - t0) >= (WIN + CYC - 4), "R7 cycle length",
          32'(cyc_ctr - t0), 32'(WIN + CYC - 4));
    rd(12'h0C0, 8'h12, "R3 first byte");
    rd(12'h0C5, 8'h85, "R3 middle byte");
    rd(12'h0C1, 8'hFF, "R4 unloaded byte in page");
    rd(12'h100, 8'hFF, "R4 other page");
    rd(12'h200, 8'hFF, "R8 busy write ignored");

    wr(12'h0C1, 8'hA1);
    wr(12'h0C5, 8'h11);
    wr(12'h0C5, 8'h22);
    repeat (WIN) @(negedge clk);
    poll(12'h0C5, 1'b0, 5000, f, l);
    check(f === 8'hA2, "R6 polling uses last byte", {24'h0, f}, 32'hA2);
    rd(12'h0C0, 8'h12, "R4 earlier programmed byte kept");
    rd(12'h0FF, 8'h3C, "R4 earlier programmed byte kept");
    rd(12'h0C1, 8'hA1, "R3 reload byte");
    rd(12'h0C5, 8'h22, "R11 last write wins");

    wr(12'h402, 8'h5A);
    wr(12'h7C7, 8'h66);
    repeat (WIN) @(negedge clk);
    poll(12'h407, 1'b0, 5000, f, l);
    rd(12'h402, 8'h5A, "R5 first write page");
    rd(12'h407, 8'h66, "R5 second write mapped into first page");
    rd(12'h7C7, 8'hFF, "R5 foreign page untouched");

    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
    wr(12'h555, 8'h77);
    repeat (WIN) @(negedge clk);
    poll(12'h555, 1'b0, 5000, f, l);
    check(f === 8'hF7, "R10 broken pattern gives program cycle", {24'h0, f}, 32'hF7);
    rd(12'h555, 8'h77, "R10 mismatch write loaded");
    rd(12'h56A, 8'h55, "R10 earlier pattern byte loaded");
    rd(12'h0C0, 8'h12, "R10 no erase happened");

    chip_erase();
    rd(12'h0C0, 8'hFF, "R9 second erase");
    rd(12'h407, 8'hFF, "R9 second erase");

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R2 all reads answered", sbq.size(), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule